// File: doc/BRIEF.md
# Crosspoint Switch Routing Controller

This block holds the routing setup of an eight-output, eight-input crosspoint switch. Each output owns a 4-bit routing code. A code whose top bit is clear names one of the eight inputs. A code whose top bit is set is a control code, and the output's buffer input is then grounded. Codes are written into a staging (first) rank. A transfer copies the whole staging rank into an active (second) rank, and the active rank drives the per-output decoders. A transfer is started by a strobe edge, by a strobe level, or by a command code.

Codes arrive through one write strobe, which works in one of two modes. In serial mode each rising strobe edge shifts one bit of a 32-bit chain in from `data_in[0]`. The bit that falls off the far end of the chain is presented on `ser_out`, so several devices can be chained together. In parallel mode each rising strobe edge stores `data_in` into the staging slot that `addr` names. The write strobe and the latch strobe are asynchronous. Each passes through a two-flop synchronizer, and its rising edge is detected in the `clk` domain.

Top module: `xpt_route_ctrl`

## Requirements
- R1: After reset both ranks hold code 4'b1000 in every slot. Every `out_gnd` bit is then 1, every `out_sel` field is 0, and `ser_out` is 1.
- R2: Output k's decoder reads active-rank code c. When c[3]=0, `out_sel[3k+2:3k]` = c[2:0] and `out_gnd[k]` = 0. When c[3]=1, `out_sel` for k is 0 and `out_gnd[k]` = 1.
- R3: In parallel mode (`ser_mode`=0), a rising edge of `wr_strobe` stores `data_in` into staging slot `addr`. No other slot changes.
- R4: `wr_strobe` has no effect unless `cs_n`=0 and `cs`=1 at the detected edge.
- R5: In serial mode (`ser_mode`=1), each enabled rising edge of `wr_strobe` shifts `data_in[0]` into the chain. Bits go in most-significant first, with output 7's code first. After 32 shifts, output k holds chain bits [4k+3:4k], and output 0's code sits nearest the input.
- R6: `ser_out` shows the bit at the far end of the chain, which is staging bit 31. A stream therefore reappears on `ser_out` delayed by 32 write edges.
- R7: With `edge_mode`=1, the active rank copies the staging rank on each rising edge of `latch_in`. At all other times it holds.
- R8: With `edge_mode`=0, the active rank follows the staging rank while `latch_in` is low. It holds while `latch_in` is high.
- R9: In parallel mode, a write of a code from 4'b1011 to 4'b1110 stores the code and then copies the staging rank (the new code included) into the active rank.
- R10: In parallel mode, a write of code 4'b1111 stores the code. It copies the staging rank into the active rank only if `latch_in` is high at that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ser_mode | input | 1 | 1 = serial chain writes, 0 = addressed parallel writes |
| edge_mode | input | 1 | 1 = transfer on latch rising edge, 0 = transparent while latch low |
| wr_strobe | input | 1 | Asynchronous write strobe, acts on rising edge |
| latch_in | input | 1 | Asynchronous rank-transfer strobe |
| cs_n | input | 1 | Active-low write enable |
| cs | input | 1 | Active-high write enable |
| addr | input | 3 | Output slot for parallel writes |
| data_in | input | 4 | Parallel code; bit 0 is the serial input |
| ser_out | output | 1 | Far end of the serial chain, for cascading |
| out_sel | output | 24 | Per-output 3-bit input select, output k at [3k+2:3k] |
| out_gnd | output | 8 | Per-output ground-the-input flag |

## Verification
The bench probes the boundary between staging and active ranks. A write in edge mode while the latch is high must stay invisible until the next latch rise. A design that let it through would move outputs early. The bench writes code 1111 once with the latch low and once with it high. A design that ignored the latch level, or treated 1111 like 1011 to 1110, would transfer on the wrong write. A serial stream is checked for slot order and for its reappearance on `ser_out` 32 edges later, which catches a reversed chain or an off-by-one tap. Disabled writes are checked by reading the outputs after a transfer, which exposes any enable that was decoded with the wrong polarity.

// File: rtl/xpt_pkg.sv
package xpt_pkg;
    localparam int N_OUT  = 8;
    localparam int SEL_W  = 3;
    localparam int CODE_W = SEL_W + 1;
    localparam int CHAIN_W = N_OUT * CODE_W;

    typedef logic [CODE_W-1:0] code_t;

    typedef struct packed {
        logic             gnd;
        logic [SEL_W-1:0] sel;
    } route_t;

    localparam code_t CODE_GND = code_t'(1) << SEL_W;

    // commands that transfer the staging rank as they are written
    function automatic logic is_imm_xfer(code_t c);
        return c[CODE_W-1] && (c[SEL_W-1:0] >= 3) && (c[SEL_W-1:0] <= 6);
    endfunction

    // command that transfers only while the latch strobe is high
    function automatic logic is_soft_latch(code_t c);
        return &c;
    endfunction

    function automatic route_t decode(code_t c);
        route_t r;
        r.gnd = c[CODE_W-1];
        r.sel = c[CODE_W-1] ? '0 : c[SEL_W-1:0];
        return r;
    endfunction
endpackage

// File: rtl/xpt_sync.sv
module xpt_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic async_in,
    output logic level,
    output logic rise
);
    logic [STAGES-1:0] pipe;
    logic              prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            pipe <= '0;
            prev <= 1'b0;
        end else begin
            pipe <= {pipe[STAGES-2:0], async_in};
            prev <= pipe[STAGES-1];
        end
    end

    assign level = pipe[STAGES-1];
    assign rise  = pipe[STAGES-1] & ~prev;

    // R3: a detected edge lasts one cycle only
    assert_single_pulse_R3: assert property (@(posedge clk) disable iff (rst)
        rise |=> !rise);
endmodule

// File: rtl/xpt_rank1.sv
module xpt_rank1
    import xpt_pkg::*;
#(
    parameter int NO = N_OUT,
    parameter int CW = CODE_W
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_pulse,
    input  logic               wr_en,
    input  logic               ser_mode,
    input  logic               latch_lvl,
    input  logic [$clog2(NO)-1:0] addr,
    input  logic [CW-1:0]      din,
    output logic [NO*CW-1:0]   stage,
    output logic               cmd_xfer,
    output logic               ser_out
);
    localparam int TOT = NO * CW;
    localparam logic [TOT-1:0] RESET_IMG = {NO{CODE_GND}};

    logic do_wr;
    assign do_wr = wr_pulse & wr_en;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage    <= RESET_IMG;
            cmd_xfer <= 1'b0;
        end else begin
            cmd_xfer <= 1'b0;
            if (do_wr) begin
                if (ser_mode) begin
                    stage <= {stage[TOT-2:0], din[0]};
                end else begin
                    stage[int'(addr)*CW +: CW] <= din;
                    cmd_xfer <= is_imm_xfer(din) || (is_soft_latch(din) && latch_lvl);
                end
            end
        end
    end

    assign ser_out = stage[TOT-1];

    // R4: without an enabled write the staging rank holds
    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !do_wr |=> $stable(stage));
    // R6: a serial shift moves the next bit onto the cascade output
    assert_ser_shift_R6: assert property (@(posedge clk) disable iff (rst)
        (do_wr && ser_mode) |=> ser_out == $past(stage[TOT-2]));
    // R9: a command transfer request follows only a parallel write
    assert_cmd_src_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_xfer |-> $past(do_wr && !ser_mode));
endmodule

// File: rtl/xpt_rank2.sv
module xpt_rank2
    import xpt_pkg::*;
#(
    parameter int TOT = CHAIN_W
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           edge_mode,
    input  logic           latch_lvl,
    input  logic           latch_rise,
    input  logic           cmd_xfer,
    input  logic [TOT-1:0] stage,
    output logic [TOT-1:0] active
);
    localparam logic [TOT-1:0] RESET_IMG = {(TOT/CODE_W){CODE_GND}};

    logic strobe_load;
    always_comb begin
        if (edge_mode) strobe_load = latch_rise;
        else           strobe_load = ~latch_lvl;
    end

    always_ff @(posedge clk) begin
        if (rst)                          active <= RESET_IMG;
        else if (strobe_load || cmd_xfer) active <= stage;
    end

    // R9/R10: a command transfer copies the staging rank
    assert_cmd_copy_R9: assert property (@(posedge clk) disable iff (rst)
        cmd_xfer |=> active == $past(stage));
    // R8: level mode with latch high and no command holds
    assert_level_hold_R8: assert property (@(posedge clk) disable iff (rst)
        (!edge_mode && latch_lvl && !cmd_xfer) |=> $stable(active));
    // R7: edge mode holds between latch edges
    assert_edge_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (edge_mode && !latch_rise && !cmd_xfer) |=> $stable(active));
endmodule

// File: rtl/xpt_route_ctrl.sv
module xpt_route_ctrl
    import xpt_pkg::*;
#(
    parameter int NO = N_OUT,
    parameter int SW = SEL_W
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 ser_mode,
    input  logic                 edge_mode,
    input  logic                 wr_strobe,
    input  logic                 latch_in,
    input  logic                 cs_n,
    input  logic                 cs,
    input  logic [$clog2(NO)-1:0] addr,
    input  logic [SW:0]          data_in,
    output logic                 ser_out,
    output logic [NO*SW-1:0]     out_sel,
    output logic [NO-1:0]        out_gnd
);
    localparam int CW  = SW + 1;
    localparam int TOT = NO * CW;

    logic wr_lvl, wr_rise, latch_lvl, latch_rise, cmd_xfer;
    logic [TOT-1:0] stage, active;

    xpt_sync #(.STAGES(2)) u_wr_sync (
        .clk(clk), .rst(rst), .async_in(wr_strobe),
        .level(wr_lvl), .rise(wr_rise)
    );

    xpt_sync #(.STAGES(2)) u_latch_sync (
        .clk(clk), .rst(rst), .async_in(latch_in),
        .level(latch_lvl), .rise(latch_rise)
    );

    xpt_rank1 #(.NO(NO), .CW(CW)) u_rank1 (
        .clk(clk), .rst(rst), .wr_pulse(wr_rise), .wr_en(~cs_n & cs),
        .ser_mode(ser_mode), .latch_lvl(latch_lvl), .addr(addr),
        .din(data_in), .stage(stage), .cmd_xfer(cmd_xfer), .ser_out(ser_out)
    );

    xpt_rank2 #(.TOT(TOT)) u_rank2 (
        .clk(clk), .rst(rst), .edge_mode(edge_mode), .latch_lvl(latch_lvl),
        .latch_rise(latch_rise), .cmd_xfer(cmd_xfer), .stage(stage),
        .active(active)
    );

    for (genvar k = 0; k < NO; k++) begin : g_dec
        route_t r;
        assign r = decode(active[k*CW +: CW]);
        assign out_sel[k*SW +: SW] = r.sel;
        assign out_gnd[k]          = r.gnd;
    end

    // R1: reset grounds every output on the next cycle
    assert_reset_gnd_R1: assert property (@(posedge clk)
        rst |=> (&out_gnd && out_sel == '0));
    // R2: a grounded output never names an input
    for (genvar k = 0; k < NO; k++) begin : g_chk
        assert_gnd_sel_R2: assert property (@(posedge clk) disable iff (rst)
            out_gnd[k] |-> out_sel[k*SW +: SW] == '0);
    end

    logic unused_wr_lvl;
    assign unused_wr_lvl = wr_lvl;
endmodule

// File: tb/xpt_route_ctrl_bench.sv
module xpt_route_ctrl_bench;
    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ser_mode = 1'b0, edge_mode = 1'b1, wr_strobe = 1'b0, latch_in = 1'b1;
    logic cs_n = 1'b0, cs = 1'b1;
    logic [2:0] addr = '0;
    logic [3:0] data_in = '0;
    logic ser_out;
    logic [23:0] out_sel;
    logic [7:0] out_gnd;

    int total = 0, bad = 0;
    logic [31:0] m1, m2;
    logic [31:0] pat;

    always #2 clk = ~clk;

    xpt_route_ctrl u_xpt_route_ctrl (
        .clk(clk), .rst(rst), .ser_mode(ser_mode), .edge_mode(edge_mode),
        .wr_strobe(wr_strobe), .latch_in(latch_in), .cs_n(cs_n), .cs(cs),
        .addr(addr), .data_in(data_in), .ser_out(ser_out),
        .out_sel(out_sel), .out_gnd(out_gnd)
    );

    function automatic logic [23:0] exp_sel(logic [31:0] img);
        logic [23:0] s = '0;
        for (int k = 0; k < 8; k++)
            s[k*3 +: 3] = img[k*4+3] ? 3'd0 : img[k*4 +: 3];
        return s;
    endfunction

    function automatic logic [7:0] exp_gnd(logic [31:0] img);
        logic [7:0] g = '0;
        for (int k = 0; k < 8; k++) g[k] = img[k*4+3];
        return g;
    endfunction

    task automatic check(string tag);
        total++;
        if (out_sel !== exp_sel(m2) || out_gnd !== exp_gnd(m2) || ser_out !== m1[31]) begin
            bad++;
            $display("FAIL %s: sel=%h gnd=%h so=%b expected sel=%h gnd=%h so=%b",
                     tag, out_sel, out_gnd, ser_out, exp_sel(m2), exp_gnd(m2), m1[31]);
        end
    endtask

    task automatic settle();
        if (!edge_mode && !latch_in) m2 = m1;
    endtask

    task automatic wait_cyc(int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic do_wr(logic ser, logic [2:0] a, logic [3:0] d, logic en_n, logic en);
        @(negedge clk);
        ser_mode = ser; addr = a; data_in = d; cs_n = en_n; cs = en;
        wait_cyc(2);
        wr_strobe = 1'b1;
        wait_cyc(5);
        wr_strobe = 1'b0;
        wait_cyc(4);
        if (!en_n && en) begin
            if (ser) m1 = {m1[30:0], d[0]};
            else begin
                m1[int'(a)*4 +: 4] = d;
                if ((d[3] && d[2:0] >= 3 && d[2:0] <= 6) || (d == 4'hF && latch_in)) m2 = m1;
            end
        end
        settle();
    endtask

    task automatic do_latch(logic v);
        @(negedge clk);
        if (edge_mode && v && !latch_in) m2 = m1;
        latch_in = v;
        wait_cyc(6);
        settle();
    endtask

    task automatic set_edge(logic v);
        @(negedge clk);
        edge_mode = v;
        wait_cyc(3);
        settle();
    endtask

    initial begin
        #400000;
        bad++; total++;
        $display("FAIL watchdog: run hung");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        void'($urandom(32'h1234_5eed));
        m1 = {8{4'b1000}};
        m2 = m1;
        wait_cyc(4);
        @(negedge clk) rst = 1'b0;
        wait_cyc(2);
        check("R1 reset state");

        // edge mode, latch high: write stays staged
        do_wr(1'b0, 3'd3, 4'b0101, 1'b0, 1'b1);
        check("R7 hold before latch edge");
        do_latch(1'b0);
        check("R7 no transfer on latch fall");
        do_latch(1'b1);
        check("R3 R7 parallel write visible after latch rise");
        check("R2 decode of input select");

        // enables
        do_wr(1'b0, 3'd4, 4'b0010, 1'b1, 1'b1);
        do_wr(1'b0, 3'd4, 4'b0010, 1'b0, 1'b0);
        do_latch(1'b0); do_latch(1'b1);
        check("R4 disabled writes ignored");

        // immediate-transfer command
        do_wr(1'b0, 3'd2, 4'b0111, 1'b0, 1'b1);
        do_wr(1'b0, 3'd5, 4'b1100, 1'b0, 1'b1);
        check("R9 command transfers staging rank");

        // software latch
        do_latch(1'b0);
        do_wr(1'b0, 3'd1, 4'b0001, 1'b0, 1'b1);
        do_wr(1'b0, 3'd6, 4'b1111, 1'b0, 1'b1);
        check("R10 soft latch with latch low no transfer");
        do_latch(1'b1);
        do_wr(1'b0, 3'd0, 4'b1111, 1'b0, 1'b1);
        check("R10 soft latch with latch high transfers");

        // serial stream, output 7 first, MSB first
        pat = 32'h0123_4567;
        for (int i = 31; i >= 0; i--) begin
            do_wr(1'b1, 3'd0, {3'b000, pat[i]}, 1'b0, 1'b1);
            if (i % 8 == 0) check("R6 cascade output during shift");
        end
        do_latch(1'b0); do_latch(1'b1);
        check("R5 serial load slot order");
        total++;
        if (out_sel[2:0] !== 3'd7 || out_sel[23:21] !== 3'd0) begin
            bad++;
            $display("FAIL R5: out0=%0d out7=%0d expected out0=7 out7=0",
                     out_sel[2:0], out_sel[23:21]);
        end
        for (int i = 31; i >= 0; i--) begin
            total++;
            if (ser_out !== pat[i]) begin
                bad++;
                $display("FAIL R6: bit %0d so=%b expected %b", i, ser_out, pat[i]);
            end
            do_wr(1'b1, 3'd0, 4'b0000, 1'b0, 1'b1);
        end

        // level mode
        set_edge(1'b0);
        do_wr(1'b0, 3'd7, 4'b0110, 1'b0, 1'b1);
        check("R8 hold while latch high");
        do_latch(1'b0);
        check("R8 transparent when latch low");
        do_wr(1'b0, 3'd2, 4'b0011, 1'b0, 1'b1);
        check("R8 follows writes while latch low");

        // random mix
        for (int n = 0; n < 400; n++) begin
            int op = $urandom % 8;
            logic [3:0] d = 4'($urandom);
            logic [2:0] a = 3'($urandom);
            case (op)
                0, 1, 2, 7: do_wr(1'b0, a, d, 1'b0, 1'b1);
                3: do_wr(1'($urandom), a, d, 1'($urandom), 1'b0);
                4: do_wr(1'b1, a, d, 1'b0, 1'b1);
                5: do_latch(~latch_in);
                default: set_edge(1'($urandom));
            endcase
            check("R2 R3 R7 R8 R9 R10 random mix");
        end

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule